// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds two small control registers for system-management memory and uses them to route every CPU access. For each access it reports a routing code: the access goes to RAM, to the PCI/legacy space, or to a blackhole. The outcome depends on whether the CPU runs in system-management mode (SMM), on an open bit, a global-enable bit, a high-enable bit and a TSEG enable with a size code. The TSEG region is a window at the top of low memory, and the low memory size is supplied as an input.

Two fixed windows are decoded. The legacy low window covers 0xA0000 to 0xBFFFF. The high alias covers the same 128 KiB starting at 0xFEDA0000. A sticky lock bit seals the configuration. It is driven by a two-state machine. State `LK_UNSEALED` is entered at reset. The transition SEAL moves it to `LK_SEALED` when a write sets the lock bit. Only reset leaves `LK_SEALED`. While sealed, the open bit is held at 0 and the write masks of both registers are empty.

The router registers its decision. Each access is first classed into one region: TSEG, the low window, the high alias, DRAM or the bus. The code for that region is then chosen, so the code appears one cycle after the access is presented.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset, the control register (select 0) reads 0x00, the extension register (select 1) reads 0x00, and `route_vld` is 0.
- R2: Control register layout: bit 0 is open, bit 1 is global enable, bit 2 is lock, and bits 7:3 read 0. The lock bit is write-one-to-set. Writing 0 to it has no effect. Once set, it stays set until reset.
- R3: Whenever the lock bit is set, the open bit reads 0. This also holds when the same write sets both bits.
- R4: While locked, writes to the open and global-enable bits and to the whole extension register have no effect.
- R5: A write changes only the implemented bits whose `wr_mask` bit is 1. Extension register layout: bit 0 is TSEG enable, bits 2:1 are the size code, bit 3 is high enable, and bits 7:4 read 0. `rd_data` shows the register picked by `rd_sel` in the same cycle.
- R6: TSEG size code 0 selects 1 MiB, code 1 selects 2 MiB, code 2 selects 8 MiB and code 3 selects `EXT_TSEG_MB` MiB (default 16). With TSEG disabled the size is 0. TSEG spans [low_top - size, low_top).
- R7: An access inside TSEG routes to 10 (blackhole) outside SMM and to 00 (RAM) in SMM. TSEG takes priority over every other window. An access in SMM never yields the blackhole.
- R8: With code 10, `hole_rdata` is 0xFFFFFFFF. With any other code it is 0.
- R9: Outside SMM, the low window routes to 00 (RAM) when open is 1 and to 01 (PCI/legacy) when open is 0.
- R10: Outside SMM, the high alias routes to 00 only when open and high enable are both 1. Otherwise it routes to 01.
- R11: In SMM with global enable set, the low window also routes to 00 when high enable is 0, and the high alias also routes to 00 when high enable is 1. With global enable clear, SMM sees the non-SMM view.
- R12: Any other address routes to 00 below `low_top` and to 01 at or above it.
- R13: `route_vld` and `route` are registered. `route_vld` is 1 exactly in the cycle after `acc_valid` was 1, and the code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the control register, 1 selects the extension register |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write enable |
| rd_sel | input | 1 | Read select, same encoding as `wr_sel` |
| rd_data | output | 8 | Selected register value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_smm | input | 1 | The access comes from system-management mode |
| low_top | input | ADDR_W | Size of memory below 4 GiB |
| route_vld | output | 1 | A routing code is valid |
| route | output | 2 | 00 RAM, 01 PCI/legacy, 10 blackhole |
| hole_rdata | output | 32 | Read data for the blackhole target |

## Verification
The routing assertions assume that `low_top` is stable while accesses are in flight. They also assume it is at least as large as the biggest TSEG size, so the TSEG base never wraps. The stimulus changes `low_top` only between sweeps, and it uses values of 64 MiB and 2 GiB only. Register writes and accesses are never presented in the same cycle. The expected routes are therefore computed from settled register values. The lock checks run last in a session and are followed by a reset, so the unsealed sweeps are never affected by a set lock bit.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef enum logic [1:0] {
        RT_RAM  = 2'b00,
        RT_PCI  = 2'b01,
        RT_HOLE = 2'b10
    } route_t;

    typedef enum logic {
        LK_UNSEALED = 1'b0,
        LK_SEALED   = 1'b1
    } lock_state_t;

    typedef enum logic [2:0] {
        RG_TSEG,
        RG_LOW,
        RG_HIGH,
        RG_DRAM,
        RG_BUS
    } region_t;

    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_EXT = 1'b1;

    localparam int CTL_OPEN = 0;
    localparam int CTL_GEN  = 1;
    localparam int CTL_LOCK = 2;

    localparam int EXT_TEN  = 0;
    localparam int EXT_SZLO = 1;
    localparam int EXT_HEN  = 3;

    localparam logic [7:0] CTL_WMASK_FREE   = 8'h03;
    localparam logic [7:0] CTL_WMASK_SEALED = 8'h00;
    localparam logic [7:0] EXT_WMASK_FREE   = 8'h0F;
    localparam logic [7:0] EXT_WMASK_SEALED = 8'h00;

    localparam logic [31:0] LOW_WIN_BASE  = 32'h000A_0000;
    localparam logic [31:0] HIGH_WIN_BASE = 32'hFEDA_0000;
    localparam logic [31:0] WIN_BYTES     = 32'h0002_0000;

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic [7:0] wr_mask,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       cfg_open,
    output logic       cfg_gen,
    output logic       cfg_hen,
    output logic       cfg_ten,
    output logic [1:0] cfg_szcode
);

    lock_state_t st_q, st_d;
    logic [7:0]  ctl_q, ctl_d;
    logic [7:0]  ext_q, ext_d;
    logic [7:0]  ctl_wm, ext_wm;
    logic [7:0]  ctl_m, ext_m;
    logic        seal_req;

    assign seal_req = wr_en && (wr_sel == SEL_CTL) && wr_mask[CTL_LOCK] && wr_data[CTL_LOCK];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_UNSEALED;
        else        st_q <= st_d;
    end

    // Next state: SEAL on a write of one to the lock bit; only reset leaves SEALED
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_UNSEALED: if (seal_req) st_d = LK_SEALED;
            LK_SEALED:   st_d = LK_SEALED;
        endcase
    end

    // State outputs: write masks per state
    always_comb begin
        unique case (st_q)
            LK_UNSEALED: begin
                ctl_wm = CTL_WMASK_FREE;
                ext_wm = EXT_WMASK_FREE;
            end
            LK_SEALED: begin
                ctl_wm = CTL_WMASK_SEALED;
                ext_wm = EXT_WMASK_SEALED;
            end
        endcase
    end

    assign ctl_m = wr_mask & ctl_wm;
    assign ext_m = wr_mask & ext_wm;

    always_comb begin
        ctl_d = ctl_q;
        ext_d = ext_q;
        if (wr_en && (wr_sel == SEL_CTL)) ctl_d = (ctl_q & ~ctl_m) | (wr_data & ctl_m);
        if (wr_en && (wr_sel == SEL_EXT)) ext_d = (ext_q & ~ext_m) | (wr_data & ext_m);
        if (st_d == LK_SEALED) ctl_d[CTL_OPEN] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ext_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            ext_q <= ext_d;
        end
    end

    always_comb begin
        if (rd_sel == SEL_CTL) begin
            rd_data = ctl_q;
            rd_data[CTL_LOCK] = (st_q == LK_SEALED);
        end else begin
            rd_data = ext_q;
        end
    end

    assign cfg_open   = ctl_q[CTL_OPEN];
    assign cfg_gen    = ctl_q[CTL_GEN];
    assign cfg_ten    = ext_q[EXT_TEN];
    assign cfg_szcode = ext_q[EXT_SZLO +: 2];
    assign cfg_hen    = ext_q[EXT_HEN];

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_SEALED) |=> (st_q == LK_SEALED)); // R2
    AST_SEALED_NOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_SEALED) |-> !cfg_open); // R3
    AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_SEALED) |=> $stable(ext_q)); // R4
    AST_GEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_SEALED) |=> $stable(cfg_gen)); // R4

endmodule

// File: rtl/tseg_span.sv
module tseg_span #(
    parameter int ADDR_W = 32,
    parameter int EXT_MB = 16
) (
    input  logic              ten,
    input  logic [1:0]        szcode,
    input  logic [ADDR_W-1:0] low_top,
    output logic              tseg_on,
    output logic [ADDR_W-1:0] tseg_lo
);

    localparam int MB_SHIFT = 20;

    logic [15:0]       ext_mb;
    logic [15:0]       mb;
    logic [ADDR_W-1:0] sz;

    generate
        if (EXT_MB > 0) begin : g_ext
            assign ext_mb = 16'(EXT_MB);
        end else begin : g_noext
            assign ext_mb = '0;
        end
    endgenerate

    always_comb begin
        unique case (szcode)
            2'd0: mb = 16'd1;
            2'd1: mb = 16'd2;
            2'd2: mb = 16'd8;
            2'd3: mb = ext_mb;
        endcase
        if (!ten) mb = '0;
    end

    assign sz      = ADDR_W'({mb, {MB_SHIFT{1'b0}}});
    assign tseg_on = (sz != '0) && (low_top >= sz);
    assign tseg_lo = low_top - sz;

endmodule

// File: rtl/smram_router.sv
module smram_router
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic [ADDR_W-1:0] low_top,
    input  logic              cfg_open,
    input  logic              cfg_gen,
    input  logic              cfg_hen,
    input  logic              tseg_on,
    input  logic [ADDR_W-1:0] tseg_lo,
    output logic              route_vld,
    output logic [1:0]        route,
    output logic [31:0]       hole_rdata
);

    localparam logic [ADDR_W-1:0] LOW_LO  = ADDR_W'(LOW_WIN_BASE);
    localparam logic [ADDR_W-1:0] LOW_HI  = ADDR_W'(LOW_WIN_BASE + WIN_BYTES);
    localparam logic [ADDR_W-1:0] HIGH_LO = ADDR_W'(HIGH_WIN_BASE);
    localparam logic [ADDR_W-1:0] HIGH_HI = ADDR_W'(HIGH_WIN_BASE + WIN_BYTES);

    region_t rg;
    route_t  rt_d, rt_q;
    logic    vld_q;
    logic    smm_low_map, smm_high_map;

    // Classify the access; TSEG first, then the fixed windows
    always_comb begin
        if (tseg_on && acc_addr >= tseg_lo && acc_addr < low_top) rg = RG_TSEG;
        else if (acc_addr >= LOW_LO && acc_addr < LOW_HI)          rg = RG_LOW;
        else if (acc_addr >= HIGH_LO && acc_addr < HIGH_HI)        rg = RG_HIGH;
        else if (acc_addr < low_top)                               rg = RG_DRAM;
        else                                                       rg = RG_BUS;
    end

    assign smm_low_map  = acc_smm && cfg_gen && !cfg_hen;
    assign smm_high_map = acc_smm && cfg_gen && cfg_hen;

    always_comb begin
        unique case (rg)
            RG_TSEG: rt_d = acc_smm ? RT_RAM : RT_HOLE;
            RG_LOW:  rt_d = (cfg_open || smm_low_map) ? RT_RAM : RT_PCI;
            RG_HIGH: rt_d = ((cfg_open && cfg_hen) || smm_high_map) ? RT_RAM : RT_PCI;
            RG_DRAM: rt_d = RT_RAM;
            default: rt_d = RT_PCI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            rt_q  <= RT_RAM;
        end else begin
            vld_q <= acc_valid;
            if (acc_valid) rt_q <= rt_d;
        end
    end

    assign route_vld  = vld_q;
    assign route      = rt_q;
    assign hole_rdata = (vld_q && rt_q == RT_HOLE) ? 32'hFFFF_FFFF : 32'h0;

    AST_SMM_NO_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_smm) |=> (route != RT_HOLE)); // R7
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> route_vld); // R13
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !route_vld); // R13
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        route_vld |-> (route != 2'b11)); // R13

endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int EXT_TSEG_MB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        wr_mask,
    input  logic              rd_sel,
    output logic [7:0]        rd_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic [ADDR_W-1:0] low_top,
    output logic              route_vld,
    output logic [1:0]        route,
    output logic [31:0]       hole_rdata
);

    logic              cfg_open, cfg_gen, cfg_hen, cfg_ten;
    logic [1:0]        cfg_szcode;
    logic              tseg_on;
    logic [ADDR_W-1:0] tseg_lo;

    smram_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .cfg_open   (cfg_open),
        .cfg_gen    (cfg_gen),
        .cfg_hen    (cfg_hen),
        .cfg_ten    (cfg_ten),
        .cfg_szcode (cfg_szcode)
    );

    tseg_span #(.ADDR_W(ADDR_W), .EXT_MB(EXT_TSEG_MB)) u_span (
        .ten     (cfg_ten),
        .szcode  (cfg_szcode),
        .low_top (low_top),
        .tseg_on (tseg_on),
        .tseg_lo (tseg_lo)
    );

    smram_router #(.ADDR_W(ADDR_W)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_smm    (acc_smm),
        .low_top    (low_top),
        .cfg_open   (cfg_open),
        .cfg_gen    (cfg_gen),
        .cfg_hen    (cfg_hen),
        .tseg_on    (tseg_on),
        .tseg_lo    (tseg_lo),
        .route_vld  (route_vld),
        .route      (route),
        .hole_rdata (hole_rdata)
    );

endmodule

// File: tb/sim_smram_tseg_ctrl.sv
`timescale 1ns/1ps
module sim_smram_tseg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0]  wr_data = '0, wr_mask = '0, rd_data;
    logic        acc_valid = 1'b0, acc_smm = 1'b0;
    logic [31:0] acc_addr = '0, low_top = 32'h8000_0000;
    logic        route_vld;
    logic [1:0]  route;
    logic [31:0] hole_rdata;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smram_tseg_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_sel(rd_sel), .rd_data(rd_data), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_smm(acc_smm), .low_top(low_top),
        .route_vld(route_vld), .route(route), .hole_rdata(hole_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(logic sel, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, logic sel, logic [7:0] exp);
        rd_sel = sel; #0.5;
        check(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    function automatic logic [1:0] exp_route(logic [31:0] a, logic smm, logic op, logic gn,
                                             logic hn, logic tn, logic [1:0] code, logic [31:0] low);
        logic [31:0] sz;
        case (code)
            2'd0: sz = 32'd1 << 20;
            2'd1: sz = 32'd2 << 20;
            2'd2: sz = 32'd8 << 20;
            default: sz = 32'd16 << 20;
        endcase
        if (!tn) sz = 0;
        if (sz != 0 && a >= low - sz && a < low) return smm ? 2'b00 : 2'b10;
        if (a >= 32'h000A_0000 && a < 32'h000C_0000)
            return (op || (smm && gn && !hn)) ? 2'b00 : 2'b01;
        if (a >= 32'hFEDA_0000 && a < 32'hFEDC_0000)
            return ((op && hn) || (smm && gn && hn)) ? 2'b00 : 2'b01;
        return (a < low) ? 2'b00 : 2'b01;
    endfunction

    task automatic access(string req, logic [31:0] a, logic smm, logic [1:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_smm = smm;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " vld"}, {31'h0, route_vld}, 32'h1);
        check(req, {30'h0, route}, {30'h0, exp});
        check({req, " R8 fill"}, hole_rdata, (exp == 2'b10) ? 32'hFFFF_FFFF : 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] addrs [16];
        do_reset();
        // R1 reset state
        rd_check("R1 ctl", 1'b0, 8'h00);
        rd_check("R1 ext", 1'b1, 8'h00);
        check("R1 vld", {31'h0, route_vld}, 32'h0);

        // R5 masking and unimplemented bits
        wr(1'b0, 8'h03, 8'h01);
        rd_check("R5 partial mask", 1'b0, 8'h01);
        wr(1'b0, 8'hFB, 8'hFF);
        rd_check("R5 ctl upper bits", 1'b0, 8'h03);
        wr(1'b1, 8'hFF, 8'hFF);
        rd_check("R5 ext upper bits", 1'b1, 8'h0F);
        wr(1'b1, 8'h00, 8'h06);
        rd_check("R5 ext mask", 1'b1, 8'h09);

        // R13 idle gives no valid
        @(negedge clk);
        check("R13 idle", {31'h0, route_vld}, 32'h0);

        // R6 R7 R9 R10 R11 R12 sweep over configurations and addresses
        for (int li = 0; li < 2; li++) begin
            low_top = (li == 0) ? 32'h0400_0000 : 32'h8000_0000;
            addrs[0] = 32'h000A_0000; addrs[1] = 32'h000B_FFFF; addrs[2] = 32'h000C_0000;
            addrs[3] = 32'h0009_FFFF; addrs[4] = 32'hFEDA_0000; addrs[5] = 32'hFEDB_FFFF;
            addrs[6] = 32'hFEDC_0000; addrs[7] = low_top - 1;   addrs[8] = low_top - (32'd1 << 20);
            addrs[9] = low_top - (32'd1 << 20) - 1; addrs[10] = low_top - (32'd8 << 20);
            addrs[11] = low_top - (32'd8 << 20) - 1; addrs[12] = low_top - (32'd16 << 20);
            addrs[13] = low_top - (32'd16 << 20) - 1; addrs[14] = low_top; addrs[15] = 32'h0000_1000;
            for (int cfg = 0; cfg < 64; cfg++) begin
                logic op, gn, hn, tn;
                logic [1:0] cd;
                op = cfg[0]; gn = cfg[1]; hn = cfg[2]; tn = cfg[3]; cd = cfg[5:4];
                wr(1'b0, {6'h0, gn, op}, 8'h03);
                wr(1'b1, {4'h0, hn, cd, tn}, 8'h0F);
                for (int ai = 0; ai < 16; ai++) begin
                    for (int s = 0; s < 2; s++) begin
                        access("R6 R7 R9 R10 R11 R12 route", addrs[ai], s[0],
                               exp_route(addrs[ai], s[0], op, gn, hn, tn, cd, low_top));
                    end
                end
            end
        end

        // R2 R3 R4 lock behaviour
        low_top = 32'h8000_0000;
        wr(1'b1, 8'h0B, 8'hFF);
        wr(1'b0, 8'h03, 8'hFF);
        rd_check("R5 before lock", 1'b0, 8'h03);
        wr(1'b0, 8'h07, 8'hFF);
        rd_check("R3 lock clears open", 1'b0, 8'h06);
        wr(1'b0, 8'h00, 8'hFF);
        rd_check("R2 lock sticky R4 gen frozen", 1'b0, 8'h06);
        wr(1'b0, 8'h01, 8'h01);
        rd_check("R4 open ignored", 1'b0, 8'h06);
        wr(1'b1, 8'h00, 8'hFF);
        rd_check("R4 ext frozen", 1'b1, 8'h0B);
        access("R4 R9 low closed after lock", 32'h000A_0000, 1'b0, 2'b01);
        access("R11 smm high after lock", 32'hFEDA_0000, 1'b1, 2'b00);
        access("R7 tseg hole after lock", 32'h7FFF_FFF0, 1'b0, 2'b10);
        do_reset();
        rd_check("R2 reset clears lock", 1'b0, 8'h00);
        rd_check("R1 ext after reset", 1'b1, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule